// File: doc/BRIEF.md
# Countdown Interrupt Timer

This block is a 16-bit countdown timer that sits behind a small write-only register interface on a peripheral adapter. Software writes the start value as two bytes, a low byte and a high byte. It then writes a control register to arm the timer. While armed, the counter steps down by one on every CPU clock. When it steps from one to zero, the block raises a level interrupt request.

The interrupt stays asserted until software reads the status byte, whose bit 0 reports the pending timer event. The read acknowledges and clears the event. The timer is one-shot. Once it reaches zero it stays there until software arms it again. Disarming the timer halts the count where it stands and drops any pending interrupt.

Top module: `disk_irq_timer`

## Requirements
- R1: After reset the counter is 0, the timer is disarmed, `irq` is low and `status_byte` is 8'h00.
- R2: A write with `wr_sel` = 0 latches `wr_data` as the low byte of the start value. A write with `wr_sel` = 1 latches it as the high byte. Neither write alters a running counter.
- R3: A write with `wr_sel` = 2 and `wr_data[1]` = 1 arms the timer and loads the counter with {high byte, low byte} on that edge. All other bits of that write are ignored.
- R4: While the timer is armed and the counter is nonzero, the counter decreases by exactly one on each clock edge that carries no control write.
- R5: On the edge where an armed counter steps from 1 to 0, the pending flag sets. From then on `irq` is high, `status_byte[0]` is 1, and `status_byte[7:1]` stays 0.
- R6: A counter at 0 stays at 0 without repeating until the next arming write. Arming with a start value of 0 raises no interrupt.
- R7: A `stat_rd` pulse clears the pending flag on that edge.
- R8: A `stat_rd` pulse on the same edge as a 1-to-0 step leaves the flag set.
- R9: A write with `wr_sel` = 2 and `wr_data[1]` = 0 disarms the timer, holds the counter value and clears the pending flag on that edge.
- R10: A write with `wr_sel` = 3 has no effect on the counter, the latched bytes, the flag or the armed state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 2 | Register select: 0 low byte, 1 high byte, 2 control, 3 unused |
| wr_data | input | 8 | Write data |
| stat_rd | input | 1 | Status read strobe; acknowledges the timer event |
| irq | output | 1 | Level interrupt request |
| status_byte | output | 8 | Status value; bit 0 is the pending timer event |
| count | output | 16 | Present counter value |

## Verification
Every result is due one edge after its stimulus. A load, a decrement, a flag change or an acknowledge driven before edge k shows up on the outputs right after edge k. A start value of N therefore raises `irq` N edges after the arming edge. The bench drives inputs on the falling edge and advances its reference model at the rising edge. It compares the outputs at the following falling edge, so each check samples exactly one edge after its stimulus. The directed cases cover the zero-crossing coinciding with a read, disarming mid-count, disarming with an event pending, and arming with zero.

// File: rtl/disk_irq_timer.sv
module disk_irq_timer #(
  parameter int CNT_W  = 16,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [1:0]        wr_sel,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              stat_rd,
  output logic              irq,
  output logic [DATA_W-1:0] status_byte,
  output logic [CNT_W-1:0]  count
);

  localparam int HI_W = CNT_W - DATA_W;

  logic [DATA_W-1:0] lo_q;
  logic [HI_W-1:0]   hi_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              armed_q;
  logic              flag_q;

  wire ctrl_wr = wr_en && (wr_sel == 2'd2);
  wire arm     = ctrl_wr && wr_data[1];
  wire disarm  = ctrl_wr && !wr_data[1];
  wire ticking = armed_q && (cnt_q != '0) && !ctrl_wr;
  wire hit     = ticking && (cnt_q == CNT_W'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lo_q <= '0;
      hi_q <= '0;
    end else if (wr_en && wr_sel == 2'd0) begin
      lo_q <= wr_data;
    end else if (wr_en && wr_sel == 2'd1) begin
      hi_q <= wr_data[HI_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      armed_q <= 1'b0;
    end else if (arm) begin
      cnt_q   <= {hi_q, lo_q};
      armed_q <= 1'b1;
    end else if (disarm) begin
      armed_q <= 1'b0;
    end else if (ticking) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      flag_q <= 1'b0;
    else if (disarm) flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;
    else if (stat_rd) flag_q <= 1'b0;
  end

  assign irq         = flag_q;
  assign status_byte = {{(DATA_W-1){1'b0}}, flag_q};
  assign count       = cnt_q;

  AST_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 && wr_data[1] |=> count == {$past(hi_q), $past(lo_q)}); // R3
  AST_DECREMENT: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && count != '0 && !(wr_en && wr_sel == 2'd2) |=> count == $past(count) - 1'b1); // R4
  AST_ZERO_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q && count == CNT_W'(1) && !(wr_en && wr_sel == 2'd2) |=> irq && status_byte[0]); // R5
  AST_STUCK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    count == '0 && !(wr_en && wr_sel == 2'd2) |=> count == '0); // R6
  AST_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && !(armed_q && count == CNT_W'(1)) |=> !irq); // R7
  AST_RACE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    stat_rd && armed_q && count == CNT_W'(1) && !(wr_en && wr_sel == 2'd2) |=> irq); // R8
  AST_DISARM: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_sel == 2'd2 && !wr_data[1] |=> !irq && $stable(count)); // R9
  AST_STATUS_UPPER: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[DATA_W-1:1] == '0); // R5

endmodule

// File: tb/disk_irq_timer_test.sv
module disk_irq_timer_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0;
  logic [1:0] wr_sel = 2'd0;
  logic [7:0] wr_data = 8'd0;
  logic stat_rd = 1'b0;
  logic irq;
  logic [7:0] status_byte;
  logic [15:0] count;

  int tests = 0;
  int fails = 0;

  logic [7:0]  m_lo = 0, m_hi = 0;
  logic [15:0] m_cnt = 0;
  logic        m_en = 0, m_flag = 0;

  always #2 clk = ~clk;

  disk_irq_timer uut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .stat_rd(stat_rd), .irq(irq), .status_byte(status_byte), .count(count));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] nxt_cnt(input logic we, input logic [1:0] sel,
      input logic [7:0] d);
    if (we && sel == 2'd2 && d[1]) return {m_hi, m_lo};
    if (we && sel == 2'd2) return m_cnt;
    if (m_en && m_cnt != 0) return m_cnt - 16'd1;
    return m_cnt;
  endfunction

  function automatic logic nxt_flag(input logic we, input logic [1:0] sel,
      input logic [7:0] d, input logic rd);
    logic c;
    c = we && sel == 2'd2;
    if (c && !d[1]) return 1'b0;
    if (!c && m_en && m_cnt == 16'd1) return 1'b1;
    if (rd) return 1'b0;
    return m_flag;
  endfunction

  task automatic step(input logic we, input logic [1:0] sel, input logic [7:0] d, input logic rd);
    logic [15:0] nc;
    logic nf;
    wr_en = we; wr_sel = sel; wr_data = d; stat_rd = rd;
    nc = nxt_cnt(we, sel, d);
    nf = nxt_flag(we, sel, d, rd);
    @(posedge clk);
    m_cnt = nc; m_flag = nf;
    if (we && sel == 2'd2) m_en = d[1];
    if (we && sel == 2'd0) m_lo = d;
    if (we && sel == 2'd1) m_hi = d;
    @(negedge clk);
    wr_en = 0; stat_rd = 0;
    chk("R4 count vs model", count, m_cnt);
    chk("R5 irq vs model", irq, m_flag);
    chk("R5 status vs model", status_byte, {7'd0, m_flag});
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0);
  endtask

  task automatic load(input logic [15:0] v);
    step(1, 2'd0, v[7:0], 0);
    step(1, 2'd1, v[15:8], 0);
    step(1, 2'd2, 8'hFE, 0);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    chk("R1 reset count", count, 0);
    chk("R1 reset irq", irq, 0);
    chk("R1 reset status", status_byte, 0);
    rst_n = 1'b1;

    load(16'd5);
    chk("R3 loaded value", count, 16'd5);
    idle(4);
    chk("R5 no irq before zero", irq, 0);
    idle(1);
    chk("R5 irq at zero", irq, 1);
    chk("R5 status bit0", status_byte, 8'h01);
    idle(3);
    chk("R6 stays zero", count, 0);
    chk("R6 irq held", irq, 1);
    step(0, 0, 0, 1);
    chk("R7 read clears", irq, 0);

    step(1, 2'd3, 8'hFF, 0);
    step(1, 2'd2, 8'h02, 0);
    chk("R10 sel3 ignored", count, 16'd5);
    step(1, 2'd0, 8'h00, 0);
    step(1, 2'd1, 8'h00, 0);
    chk("R2 byte writes keep running count", count, 16'd3);
    step(1, 2'd2, 8'h02, 0);
    idle(3);
    chk("R6 zero load no irq", irq, 0);

    step(1, 2'd0, 8'd3, 0);
    step(1, 2'd2, 8'hFF, 0);
    idle(1);
    step(1, 2'd2, 8'hFD, 0);
    chk("R9 disarm holds count", count, 16'd2);
    idle(4);
    chk("R9 stays stopped", count, 16'd2);
    chk("R9 no irq after disarm", irq, 0);

    step(1, 2'd0, 8'd1, 0);
    step(1, 2'd2, 8'h02, 0);
    idle(1);
    chk("R5 irq from one", irq, 1);
    step(1, 2'd2, 8'h00, 0);
    chk("R9 disarm clears flag", irq, 0);

    step(1, 2'd0, 8'd2, 0);
    step(1, 2'd2, 8'h02, 0);
    idle(1);
    step(0, 0, 0, 1);
    chk("R8 read on zero edge keeps flag", irq, 1);
    step(0, 0, 0, 1);
    chk("R7 later read clears", irq, 0);

    step(1, 2'd1, 8'h01, 0);
    step(1, 2'd0, 8'h04, 0);
    step(1, 2'd2, 8'h02, 0);
    chk("R3 high byte loaded", count, 16'h0104);
    idle(16'h0104);
    chk("R4 counted to zero", count, 0);
    chk("R5 irq after long count", irq, 1);

    for (int i = 0; i < 4000; i++) begin
      logic [31:0] r;
      r = $urandom;
      case (r[3:0])
        4'd0: step(1, 2'd0, {3'd0, r[8:4]}, r[12]);
        4'd1: step(1, 2'd1, (r[13:11] == 0) ? 8'd1 : 8'd0, r[12]);
        4'd2: step(1, 2'd2, r[11:4], r[12]);
        4'd3: step(1, 2'd3, r[11:4], r[12]);
        4'd4, 4'd5: step(0, 0, 0, 1);
        default: step(0, 0, 0, 0);
      endcase
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule